// File: doc/BRIEF.md
# Flash Operation Sequencer

This block turns a single software command into a series of word-sized requests on a request/acknowledge port that faces a flash primitive. A command names the kind of operation (read, program or erase), the program flavour (normal or repair), the erase scope (page or bank), the partition, a word count stored as one less than the real count, and a byte start address. Once started, the sequencer aligns the address to suit the operation, walks it one word per acknowledged request, and signals completion through sticky done and error flags and a one-cycle interrupt pulse.

While an operation is running, the command register is write-locked by hardware. Any write, including a second start, is discarded. Access permission is not decided here. A one-bit grant input stands for it, and a denied word stops the operation and records where it failed. A per-type program enable, which can only be cleared, rejects disallowed program flavours. A suspend request is forwarded to the flash only while an erase is actually running.

Top module: `flash_op_sequencer`

## Requirements
- R1: The operation code is 0 for read, 1 for program and 2 for erase. The code, repair bit (1 = repair program), bank bit (1 = bank erase) and partition bit (1 = info partition, or for a bank erase, info erased along with data) appear unchanged on the flash port while the request is up.
- R2: A read or program with count field N issues exactly N+1 requests. The address steps up by WORD_BYTES after each acknowledge, and it stays stable while a request waits for its acknowledge.
- R3: For read and program, the start address is rounded down to a multiple of WORD_BYTES. For example, 0x13 becomes 0x10.
- R4: An erase issues one request. A page erase rounds the address down to a multiple of WORD_BYTES*WORDS_PER_PAGE (64 by default). A bank erase rounds it down to a multiple of one bank (256 by default).
- R5: cmd_lock_en_o is 1 out of reset. It reads 0 from the cycle after a start until the operation finishes, whether it succeeds or fails. While it is 0, command writes change neither the readback nor start anything.
- R6: On completion, done_o is set together with a single-cycle op_done_irq_o. done_o and err_o stay set until status_clr_i bit 0 (done) or bit 1 (error and both cause flags) clears them.
- R7: ptype_en_o resets to 2'b11 (bit 0 normal, bit 1 repair). A 1 on a bit of ptype_clear_i clears that bit, and no input can set it again. A program of a disabled type completes with err_o and err_ptype_o set and issues no request.
- R8: If grant_i is low when a word is due, the operation ends with err_o and err_perm_o set, and err_addr_o holds that word's byte address. Words before it complete normally.
- R9: A suspend request made while no erase is running leaves suspend_pending_o at 0. A request made during an erase sets suspend_pending_o and flash_suspend_o until flash_suspend_ack_i is seen.
- R10: A start with operation code 3 completes with err_o set and issues no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_we_i | input | 1 | Command register write strobe |
| cmd_start_i | input | 1 | Start bit written with the command |
| cmd_op_i | input | 2 | Operation code |
| cmd_repair_i | input | 1 | 1 = repair program |
| cmd_bank_i | input | 1 | 1 = bank erase |
| cmd_info_i | input | 1 | Partition select |
| cmd_num_i | input | NUM_W | Word count minus one |
| cmd_addr_i | input | ADDR_W | Start byte address |
| cmd_lock_en_o | output | 1 | 1 = command register writable |
| cmd_op_o | output | 2 | Readback of operation code |
| cmd_num_o | output | NUM_W | Readback of count |
| cmd_addr_o | output | ADDR_W | Readback of raw address |
| ptype_clear_i | input | 2 | Clear strobes for the program-type enables |
| ptype_en_o | output | 2 | Program-type enables |
| grant_i | input | 1 | Permission for the current word |
| status_clr_i | input | 2 | Bit 0 clears done, bit 1 clears the error flags |
| done_o | output | 1 | Operation done flag |
| err_o | output | 1 | Operation error flag |
| err_perm_o | output | 1 | Permission error cause |
| err_ptype_o | output | 1 | Program-type error cause |
| err_addr_o | output | ADDR_W | Address of the denied word |
| op_done_irq_o | output | 1 | Completion pulse |
| suspend_req_i | input | 1 | Erase-suspend request pulse |
| suspend_pending_o | output | 1 | Suspend request outstanding |
| flash_suspend_o | output | 1 | Suspend request to flash |
| flash_suspend_ack_i | input | 1 | Flash has serviced the suspend |
| fl_req_o | output | 1 | Flash request |
| fl_op_o | output | 2 | Flash operation code |
| fl_repair_o | output | 1 | Flash repair-program select |
| fl_bank_o | output | 1 | Flash bank-erase select |
| fl_info_o | output | 1 | Flash partition select |
| fl_addr_o | output | ADDR_W | Flash byte address |
| fl_ack_i | input | 1 | Flash acknowledge |

## Verification
The bench starts commands while the sequencer is locked and then checks the readback and the request count afterwards. A design that honoured such a write would either change the readback or launch an unwanted second operation. Unaligned addresses go to each operation kind: a read at 0x13, and page and bank erases at odd offsets. A wrong mask shows up as a request at the raw address. A count of zero must still produce one request, which catches an off-by-one in the minus-one encoding. The grant is withdrawn part way through a burst, which shows whether the sequencer stops at the right word and records its address. Suspend requests arrive both while idle and during a stalled erase, to catch a request that lingers when nothing is erasing or one that drops before the flash acknowledges it.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_RSVD  = 2'd3
  } fop_e;

  typedef enum logic {
    S_IDLE = 1'b0,
    S_RUN  = 1'b1
  } fseq_state_e;

  typedef struct packed {
    fop_e op;
    logic repair;
    logic bank;
    logic info;
  } fmode_t;

endpackage

// File: rtl/flash_seq_walker.sv
module flash_seq_walker
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W         = 9,
  parameter int NUM_W          = 12,
  parameter int WORD_BYTES     = 4,
  parameter int WORDS_PER_PAGE = 16,
  parameter int PAGES_PER_BANK = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  fop_e              op_i,
  input  logic              bank_i,
  input  logic [ADDR_W-1:0] raw_addr_i,
  input  logic [NUM_W-1:0]  num_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  localparam int WORD_LSB = $clog2(WORD_BYTES);
  localparam int PAGE_LSB = WORD_LSB + $clog2(WORDS_PER_PAGE);
  localparam int BANK_LSB = PAGE_LSB + $clog2(PAGES_PER_BANK);
  localparam logic [ADDR_W-1:0] WORD_MASK = {ADDR_W{1'b1}} << WORD_LSB;
  localparam logic [ADDR_W-1:0] PAGE_MASK = {ADDR_W{1'b1}} << PAGE_LSB;
  localparam logic [ADDR_W-1:0] BANK_MASK = {ADDR_W{1'b1}} << BANK_LSB;

  logic [ADDR_W-1:0] addr_q, addr_d, aligned;
  logic [NUM_W-1:0]  cnt_q, cnt_d;

  always_comb begin
    if (op_i == OP_ERASE) aligned = raw_addr_i & (bank_i ? BANK_MASK : PAGE_MASK);
    else                  aligned = raw_addr_i & WORD_MASK;
  end

  always_comb begin
    addr_d = addr_q;
    cnt_d  = cnt_q;
    if (load_i) begin
      addr_d = aligned;
      cnt_d  = num_i;
    end else if (step_i) begin
      addr_d = addr_q + ADDR_W'(WORD_BYTES);
      cnt_d  = cnt_q - NUM_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (load_i || step_i) begin
      addr_q <= addr_d;
      cnt_q  <= cnt_d;
    end
  end

  assign addr_o = addr_q;
  assign last_o = (cnt_q == '0);
endmodule

// File: rtl/flash_seq_suspend.sv
module flash_seq_suspend (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic erase_active_i,
  input  logic ack_i,
  output logic pend_o
);
  logic pend_q, pend_d;

  always_comb begin
    pend_d = erase_active_i & (pend_q | req_i) & ~(pend_q & ack_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/flash_seq_status.sv
module flash_seq_status #(
  parameter int ADDR_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fin_i,
  input  logic              fin_err_i,
  input  logic              perm_err_i,
  input  logic              ptype_err_i,
  input  logic [ADDR_W-1:0] fail_addr_i,
  input  logic [1:0]        clr_i,
  output logic              done_o,
  output logic              err_o,
  output logic              err_perm_o,
  output logic              err_ptype_o,
  output logic [ADDR_W-1:0] err_addr_o,
  output logic              irq_o
);
  logic              done_q, done_d, err_q, err_d;
  logic              perm_q, perm_d, ptype_q, ptype_d, irq_q;
  logic [ADDR_W-1:0] eaddr_q;

  always_comb begin
    done_d  = fin_i       | (done_q  & ~clr_i[0]);
    err_d   = fin_err_i   | (err_q   & ~clr_i[1]);
    perm_d  = perm_err_i  | (perm_q  & ~clr_i[1]);
    ptype_d = ptype_err_i | (ptype_q & ~clr_i[1]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      perm_q  <= 1'b0;
      ptype_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      done_q  <= done_d;
      err_q   <= err_d;
      perm_q  <= perm_d;
      ptype_q <= ptype_d;
      irq_q   <= fin_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         eaddr_q <= '0;
    else if (perm_err_i) eaddr_q <= fail_addr_i;
  end

  assign done_o      = done_q;
  assign err_o       = err_q;
  assign err_perm_o  = perm_q;
  assign err_ptype_o = ptype_q;
  assign err_addr_o  = eaddr_q;
  assign irq_o       = irq_q;
endmodule

// File: rtl/flash_op_sequencer.sv
module flash_op_sequencer
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W         = 9,
  parameter int NUM_W          = 12,
  parameter int WORD_BYTES     = 4,
  parameter int WORDS_PER_PAGE = 16,
  parameter int PAGES_PER_BANK = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_we_i,
  input  logic              cmd_start_i,
  input  logic [1:0]        cmd_op_i,
  input  logic              cmd_repair_i,
  input  logic              cmd_bank_i,
  input  logic              cmd_info_i,
  input  logic [NUM_W-1:0]  cmd_num_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  output logic              cmd_lock_en_o,
  output logic [1:0]        cmd_op_o,
  output logic [NUM_W-1:0]  cmd_num_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  input  logic [1:0]        ptype_clear_i,
  output logic [1:0]        ptype_en_o,
  input  logic              grant_i,
  input  logic [1:0]        status_clr_i,
  output logic              done_o,
  output logic              err_o,
  output logic              err_perm_o,
  output logic              err_ptype_o,
  output logic [ADDR_W-1:0] err_addr_o,
  output logic              op_done_irq_o,
  input  logic              suspend_req_i,
  output logic              suspend_pending_o,
  output logic              flash_suspend_o,
  input  logic              flash_suspend_ack_i,
  output logic              fl_req_o,
  output logic [1:0]        fl_op_o,
  output logic              fl_repair_o,
  output logic              fl_bank_o,
  output logic              fl_info_o,
  output logic [ADDR_W-1:0] fl_addr_o,
  input  logic              fl_ack_i
);
  fseq_state_e       state_q, state_d;
  fmode_t            mode_q, mode_d;
  logic [NUM_W-1:0]  num_q;
  logic [ADDR_W-1:0] raw_q;
  logic [1:0]        pten_q, pten_d;
  logic capture, start, running, bad_op, bad_type, issue;
  logic fin, fin_err, perm_err, ptype_err, step, last, susp_pend;

  // command capture is only possible while unlocked
  assign capture = cmd_we_i && (state_q == S_IDLE);
  assign start   = capture && cmd_start_i;
  assign running = (state_q == S_RUN);

  always_comb begin
    mode_d.op     = fop_e'(cmd_op_i);
    mode_d.repair = cmd_repair_i;
    mode_d.bank   = cmd_bank_i;
    mode_d.info   = cmd_info_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      num_q  <= '0;
      raw_q  <= '0;
    end else if (capture) begin
      mode_q <= mode_d;
      num_q  <= cmd_num_i;
      raw_q  <= cmd_addr_i;
    end
  end

  // program-type enables: clear-only
  assign pten_d = pten_q & ~ptype_clear_i;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pten_q <= 2'b11;
    else         pten_q <= pten_d;
  end

  always_comb begin
    bad_op    = running && (mode_q.op == OP_RSVD);
    bad_type  = running && (mode_q.op == OP_PROG) && !pten_q[mode_q.repair];
    issue     = running && !bad_op && !bad_type && grant_i;
    perm_err  = running && !bad_op && !bad_type && !grant_i;
    ptype_err = bad_type;
    fin_err   = bad_op || bad_type || perm_err;
    fin       = fin_err || (issue && fl_ack_i && ((mode_q.op == OP_ERASE) || last));
    step      = issue && fl_ack_i && !fin;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (start) state_d = S_RUN;
      S_RUN:   if (fin)   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_IDLE;
    else         state_q <= state_d;
  end

  flash_seq_walker #(
    .ADDR_W(ADDR_W), .NUM_W(NUM_W), .WORD_BYTES(WORD_BYTES),
    .WORDS_PER_PAGE(WORDS_PER_PAGE), .PAGES_PER_BANK(PAGES_PER_BANK)
  ) u_walker (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(start), .op_i(mode_d.op),
    .bank_i(cmd_bank_i), .raw_addr_i(cmd_addr_i), .num_i(cmd_num_i),
    .step_i(step), .addr_o(fl_addr_o), .last_o(last)
  );

  flash_seq_suspend u_susp (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(suspend_req_i),
    .erase_active_i(running && (mode_q.op == OP_ERASE) && !fin),
    .ack_i(flash_suspend_ack_i), .pend_o(susp_pend)
  );

  flash_seq_status #(.ADDR_W(ADDR_W)) u_status (
    .clk_i(clk_i), .rst_ni(rst_ni), .fin_i(fin), .fin_err_i(fin_err),
    .perm_err_i(perm_err), .ptype_err_i(ptype_err), .fail_addr_i(fl_addr_o),
    .clr_i(status_clr_i), .done_o(done_o), .err_o(err_o),
    .err_perm_o(err_perm_o), .err_ptype_o(err_ptype_o),
    .err_addr_o(err_addr_o), .irq_o(op_done_irq_o)
  );

  assign cmd_lock_en_o     = !running;
  assign cmd_op_o          = mode_q.op;
  assign cmd_num_o         = num_q;
  assign cmd_addr_o        = raw_q;
  assign ptype_en_o        = pten_q;
  assign suspend_pending_o = susp_pend;
  assign flash_suspend_o   = susp_pend;
  assign fl_req_o          = issue;
  assign fl_op_o           = mode_q.op;
  assign fl_repair_o       = mode_q.repair;
  assign fl_bank_o         = mode_q.bank;
  assign fl_info_o         = mode_q.info;
endmodule

// File: rtl/flash_op_sequencer_chk.sv
module flash_op_sequencer_chk #(
  parameter int ADDR_W     = 9,
  parameter int WORD_BYTES = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_lock_en_o,
  input logic              fl_req_o,
  input logic              fl_ack_i,
  input logic [1:0]        fl_op_o,
  input logic [ADDR_W-1:0] fl_addr_o,
  input logic              op_done_irq_o,
  input logic              done_o,
  input logic              err_o,
  input logic              err_perm_o,
  input logic              err_ptype_o,
  input logic              flash_suspend_o,
  input logic [1:0]        ptype_en_o
);
  p_req_locked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_req_o |-> !cmd_lock_en_o);

  p_unlock_irq_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmd_lock_en_o) |-> op_done_irq_o);

  p_word_align_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_req_o && fl_op_o != 2'd2) |-> ((int'(fl_addr_o) % WORD_BYTES) == 0));

  p_addr_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_req_o && !fl_ack_i) |=> (!fl_req_o || $stable(fl_addr_o)));

  p_irq_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_done_irq_o |-> (done_o && cmd_lock_en_o));

  p_irq_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_done_irq_o |=> !op_done_irq_o);

  p_ptype_noset_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((ptype_en_o & ~$past(ptype_en_o)) == 2'b00));

  p_ptype_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_ptype_o |-> err_o);

  p_perm_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_perm_o |-> err_o);

  p_susp_erase_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flash_suspend_o |-> (!cmd_lock_en_o && fl_op_o == 2'd2));
endmodule

bind flash_op_sequencer flash_op_sequencer_chk #(
  .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_lock_en_o(cmd_lock_en_o),
  .fl_req_o(fl_req_o), .fl_ack_i(fl_ack_i), .fl_op_o(fl_op_o),
  .fl_addr_o(fl_addr_o), .op_done_irq_o(op_done_irq_o), .done_o(done_o),
  .err_o(err_o), .err_perm_o(err_perm_o), .err_ptype_o(err_ptype_o),
  .flash_suspend_o(flash_suspend_o), .ptype_en_o(ptype_en_o)
);

// File: tb/flash_op_sequencer_test.sv
module flash_op_sequencer_test;
  localparam int AW = 9;
  localparam int NW = 12;
  localparam int WB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_we = 0, cmd_start = 0, cmd_repair = 0, cmd_bank = 0, cmd_info = 0;
  logic [1:0] cmd_op = 0;
  logic [NW-1:0] cmd_num = 0;
  logic [AW-1:0] cmd_addr = 0;
  logic lock_en;
  logic [1:0] rb_op;
  logic [NW-1:0] rb_num;
  logic [AW-1:0] rb_addr;
  logic [1:0] ptype_clear = 0, ptype_en, status_clr = 0;
  logic grant = 1;
  logic done, err, err_perm, err_ptype, irq;
  logic [AW-1:0] err_addr;
  logic susp_req = 0, susp_pend, fl_susp, susp_ack = 0;
  logic fl_req, fl_repair, fl_bank, fl_info, fl_ack = 0;
  logic [1:0] fl_op;
  logic [AW-1:0] fl_addr;

  int checks = 0, errors = 0;
  int req_cnt = 0, drop_at = 1000, wait_cnt = 0;
  bit hold_ack = 0;
  logic [AW-1:0] log_addr [0:63];
  logic [1:0] seen_op;
  logic seen_repair, seen_bank, seen_info;

  always #10 clk = ~clk;

  flash_op_sequencer uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_we_i(cmd_we), .cmd_start_i(cmd_start),
    .cmd_op_i(cmd_op), .cmd_repair_i(cmd_repair), .cmd_bank_i(cmd_bank),
    .cmd_info_i(cmd_info), .cmd_num_i(cmd_num), .cmd_addr_i(cmd_addr),
    .cmd_lock_en_o(lock_en), .cmd_op_o(rb_op), .cmd_num_o(rb_num),
    .cmd_addr_o(rb_addr), .ptype_clear_i(ptype_clear), .ptype_en_o(ptype_en),
    .grant_i(grant), .status_clr_i(status_clr), .done_o(done), .err_o(err),
    .err_perm_o(err_perm), .err_ptype_o(err_ptype), .err_addr_o(err_addr),
    .op_done_irq_o(irq), .suspend_req_i(susp_req),
    .suspend_pending_o(susp_pend), .flash_suspend_o(fl_susp),
    .flash_suspend_ack_i(susp_ack), .fl_req_o(fl_req), .fl_op_o(fl_op),
    .fl_repair_o(fl_repair), .fl_bank_o(fl_bank), .fl_info_o(fl_info),
    .fl_addr_o(fl_addr), .fl_ack_i(fl_ack)
  );

  // flash model: acknowledges requests after a random delay
  always @(negedge clk) begin
    if (fl_ack) begin
      fl_ack = 1'b0;
      if (req_cnt == drop_at) grant = 1'b0;
    end else if (fl_req && !hold_ack) begin
      if (wait_cnt == 0) begin
        if (req_cnt < 64) log_addr[req_cnt] = fl_addr;
        seen_op = fl_op; seen_repair = fl_repair;
        seen_bank = fl_bank; seen_info = fl_info;
        req_cnt++;
        fl_ack = 1'b1;
        wait_cnt = $urandom % 3;
      end else wait_cnt--;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int exp_align(input int a, input int op, input bit bank);
    if (op == 2) return bank ? (a & ~255) : (a & ~63);
    return a & ~(WB - 1);
  endfunction

  task automatic issue(input int op, input bit rep, input bit bank, input bit info,
                       input int num, input int addr, input bit st);
    @(negedge clk);
    cmd_we = 1; cmd_start = st; cmd_op = op[1:0]; cmd_repair = rep;
    cmd_bank = bank; cmd_info = info; cmd_num = num[NW-1:0]; cmd_addr = addr[AW-1:0];
    @(negedge clk);
    cmd_we = 0; cmd_start = 0;
  endtask

  task automatic wait_done(output bit got);
    got = 0;
    for (int i = 0; i < 3000 && !got; i++) begin
      @(negedge clk);
      if (irq) got = 1;
    end
  endtask

  task automatic clear_status();
    @(negedge clk); status_clr = 2'b11;
    @(negedge clk); status_clr = 2'b00;
  endtask

  task automatic run_ok(input int op, input bit rep, input bit bank, input bit info,
                        input int num, input int addr, input string tag);
    bit got;
    int n, base;
    req_cnt = 0;
    issue(op, rep, bank, info, num, addr, 1);
    wait_done(got);
    chk(got && done && !err && lock_en, {tag, " R6 completes cleanly"}, {done, err}, 2'b10);
    n = (op == 2) ? 1 : num + 1;
    chk(req_cnt == n, {tag, " R2 request count"}, req_cnt, n);
    base = exp_align(addr, op, bank);
    for (int i = 0; i < n && i < 64 && i < req_cnt; i++)
      chk(int'(log_addr[i]) == ((base + i * WB) % 512), {tag, " R3 R4 address"},
          log_addr[i], (base + i * WB) % 512);
    chk(seen_op == op[1:0] && seen_repair == rep && seen_bank == bank && seen_info == info,
        {tag, " R1 flash fields"}, {seen_op, seen_repair, seen_bank, seen_info},
        {op[1:0], rep, bank, info});
    clear_status();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit got;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R5 R6 R7 R9: reset state
    chk(lock_en && !done && !err && !fl_req && !susp_pend && ptype_en == 2'b11,
        "R5 R7 R9 reset state", {lock_en, done, err, fl_req, susp_pend, ptype_en},
        7'b1000011);

    // R3: unaligned read
    run_ok(0, 0, 0, 0, 1, 'h13, "read 0x13");
    // R2: count zero still one word
    run_ok(1, 0, 0, 1, 0, 'h0E, "program one word");
    // R4: page and bank erase
    run_ok(2, 0, 0, 1, 7, 'h85, "page erase");
    run_ok(2, 0, 1, 1, 0, 'h1C7, "bank erase");

    // constrained random mix
    for (int k = 0; k < 30; k++)
      run_ok($urandom % 3, $urandom % 2, $urandom % 2, $urandom % 2,
             $urandom % 6, $urandom % 512, "random");

    // R5: writes ignored while locked
    hold_ack = 1; req_cnt = 0;
    issue(0, 0, 0, 0, 3, 'h40, 1);
    chk(!lock_en, "R5 locked while running", lock_en, 0);
    issue(2, 1, 1, 1, 5, 'h1FF, 1);
    chk(rb_op == 0 && rb_num == 3 && rb_addr == 'h40, "R5 readback unchanged",
        {rb_op, rb_num, rb_addr}, {2'd0, 12'd3, 9'h40});
    hold_ack = 0;
    wait_done(got);
    chk(got && !err, "R5 first op completes", err, 0);
    repeat (10) @(negedge clk);
    chk(lock_en && req_cnt == 4, "R5 no second op", req_cnt, 4);
    // R6: sticky done until cleared
    chk(done, "R6 done sticky", done, 1);
    clear_status();
    chk(!done && !err, "R6 cleared by software", {done, err}, 0);

    // R9: suspend while idle is dropped
    @(negedge clk); susp_req = 1;
    @(negedge clk); susp_req = 0;
    chk(!susp_pend && !fl_susp, "R9 idle suspend cleared", susp_pend, 0);

    // R9: suspend during erase held until acknowledged
    hold_ack = 1; req_cnt = 0;
    issue(2, 0, 0, 0, 0, 'h85, 1);
    @(negedge clk); susp_req = 1;
    @(negedge clk); susp_req = 0;
    chk(susp_pend && fl_susp, "R9 suspend forwarded", {susp_pend, fl_susp}, 2'b11);
    repeat (3) @(negedge clk);
    chk(susp_pend, "R9 suspend held", susp_pend, 1);
    susp_ack = 1;
    @(negedge clk); susp_ack = 0;
    chk(!susp_pend && !fl_susp, "R9 suspend cleared by ack", susp_pend, 0);
    hold_ack = 0;
    wait_done(got);
    chk(got && req_cnt == 1 && log_addr[0] == 'h80, "R4 erase after suspend",
        log_addr[0], 'h80);
    clear_status();

    // R7: disable repair program
    @(negedge clk); ptype_clear = 2'b10;
    @(negedge clk); ptype_clear = 2'b00;
    chk(ptype_en == 2'b01, "R7 repair enable cleared", ptype_en, 1);
    req_cnt = 0;
    issue(1, 1, 0, 0, 2, 'h20, 1);
    wait_done(got);
    chk(got && err && err_ptype && !err_perm && req_cnt == 0, "R7 type error",
        {err, err_ptype, err_perm, req_cnt[3:0]}, 7'b1100000);
    clear_status();
    chk(!err_ptype, "R7 type flag cleared", err_ptype, 0);
    run_ok(1, 0, 0, 0, 2, 'h20, "normal program still enabled R7");
    chk(ptype_en == 2'b01, "R7 enable stays cleared", ptype_en, 1);

    // R8: grant withdrawn at third word
    drop_at = 2; req_cnt = 0;
    issue(1, 0, 0, 0, 5, 'h20, 1);
    wait_done(got);
    chk(got && err && err_perm && req_cnt == 2, "R8 stop on denial",
        {err, err_perm, req_cnt[3:0]}, 6'b110010);
    chk(err_addr == 'h28, "R8 error address", err_addr, 'h28);
    drop_at = 1000; grant = 1;
    clear_status();

    // R8: grant low from the start
    grant = 0; req_cnt = 0;
    issue(0, 0, 0, 0, 3, 'h1F3, 1);
    wait_done(got);
    chk(got && err_perm && req_cnt == 0 && err_addr == 'h1F0, "R8 denied first word",
        err_addr, 'h1F0);
    grant = 1;
    clear_status();

    // R10: reserved op code
    req_cnt = 0;
    issue(3, 0, 0, 0, 4, 'h10, 1);
    wait_done(got);
    chk(got && err && !err_perm && !err_ptype && req_cnt == 0, "R10 reserved op",
        {err, err_perm, err_ptype}, 3'b100);
    clear_status();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule